// File: doc/BRIEF.md
# Used-Ring Completion and Interrupt Gate

This block retires finished requests into the used ring of a split virtqueue. A completion command carries the head descriptor id, the total byte count the device produced and a count of leading bytes to leave untouched. The block steps once per clock through the request's device-writable segments. For every segment that actually receives data it emits one write extent (segment index, start address, byte count). When the segments are done it issues one 8-byte write of the used element into the ring slot picked by its own running used counter.

A separate sync request publishes the running counter into the used ring's index word. In the same cycle the block decides whether the guest gets an interrupt pulse or whether the interrupt is suppressed and counted. A third request rewrites the used-ring flags word, setting or clearing the bit that asks the driver not to kick the device. All memory traffic leaves through one write port, one write per cycle. The payload copy and the interrupt line itself stay outside the block.

Top module: `ucg_used_ring`

## Requirements
- R1: After reset `ready_o` is 1, no write, extent or interrupt is issued, the skipped-interrupt count is 0 and the first used element goes to ring slot 0.
- R2: A completion ends with one write of 8 bytes at `used_base_i + 4 + 8*slot`. Data bits [31:0] hold the head id and bits [63:32] hold the full total length, never the total minus the reserved count. `ready_o` is 1 in the cycle after that write.
- R3: The slot is the running used counter modulo 2^RING_LOG2. The counter advances by one per completion and wraps to slot 0 after the last slot.
- R4: While skip bytes remain, a segment whose length is not above the remaining skip emits no extent, and its length is taken off the skip. Zero-length segments are passed over the same way.
- R5: The first segment only partly covered by the skip emits an extent at its address plus the remaining skip, with length equal to its length minus that skip. The skip is zero afterwards. Extents come out in rising segment index order.
- R6: Across all extents the bytes add up to total minus reserved, or to less when the segments run out. The last extent is cut to the bytes that remain. No extent has length zero.
- R7: If the reserved count is not below the total, no extent is emitted, but the used element is still written with the full total.
- R8: A sync writes the 16-bit running used counter (the number of completions since reset, modulo 65536) as 2 bytes at `used_base_i + 2`.
- R9: In the cycle of the sync write, `irq_o` pulses with `irq_cause_o` = 8'h01 when bit 0 of `avail_flags_i` (suppress interrupt) is 0, or when `notify_empty_i` and `queue_empty_i` are both 1.
- R10: When a sync raises no interrupt, `skip_cnt_o` rises by one. It changes at no other time.
- R11: A sync requested while a completion is in progress is held. It runs after the used element write, so the index it publishes includes that element.
- R12: A flags update writes 2 bytes at `used_base_i + 0`: the sampled `used_flags_i` word with bit 0 cleared when `flag_enable_i` is 1, or set when it is 0. The other bits are unchanged.
- R13: When idle, a completion goes before a pending sync, and a pending sync goes before a pending flags update. A write and an extent never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| used_base_i | input | AW | Byte address of the used ring |
| cmp_valid_i | input | 1 | Completion command, taken when `ready_o` is 1 |
| ready_o | output | 1 | Idle, able to take a completion |
| cmp_id_i | input | 32 | Head descriptor id |
| cmp_total_i | input | 32 | Total length reported |
| cmp_rsv_i | input | 32 | Reserved leading bytes to skip |
| cmp_nseg_i | input | NW | Number of valid segments |
| seg_addr_i | input | NSEG x AW | Segment start addresses |
| seg_len_i | input | NSEG x 32 | Segment lengths |
| sync_i | input | 1 | Request to publish the used index |
| avail_flags_i | input | 16 | Available-ring flags word, bit 0 suppresses interrupts |
| notify_empty_i | input | 1 | Notify-on-empty feature negotiated |
| queue_empty_i | input | 1 | Available queue currently empty |
| flag_req_i | input | 1 | Request to rewrite the used-ring flags word |
| flag_enable_i | input | 1 | 1 lets the driver kick (clear bit 0), 0 suppresses kicks |
| used_flags_i | input | 16 | Current used-ring flags word |
| wr_valid_o | output | 1 | Memory write strobe |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 64 | Write data, little-endian |
| wr_bytes_o | output | 4 | Write size in bytes |
| ext_valid_o | output | 1 | Segment write extent strobe |
| ext_idx_o | output | NW | Segment index |
| ext_addr_o | output | AW | Extent start address |
| ext_len_o | output | 32 | Extent byte count |
| irq_o | output | 1 | Interrupt request pulse |
| irq_cause_o | output | 8 | Cause bits, bit 0 is the queue cause |
| skip_cnt_o | output | SKIP_CW | Count of suppressed interrupts |

## Verification
The case that needs care is a sync and a completion landing in the same cycle. The bench provokes it two ways: it raises both strobes in one cycle while idle, and it raises a sync one cycle after a completion was taken, while the segment walk is still running. Each time the recorded write sequence must show the used element first and the index write second. The published index must already count the new element, and the interrupt decision must match the flag inputs held during the sync. A flags update raised together with a sync must likewise come out after the index write.

// File: rtl/ucg_pkg.sv
package ucg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_ELEM,
    ST_SYNC,
    ST_FLAG
  } ucg_state_e;

  localparam int FLAGS_OFF   = 0;
  localparam int IDX_OFF     = 2;
  localparam int RING_OFF    = 4;
  localparam int ELEM_SHIFT  = 3;
  localparam int NO_IRQ_BIT  = 0;
  localparam logic [7:0] CAUSE_QUEUE = 8'h01;
endpackage

// File: rtl/ucg_seg_walk.sv
module ucg_seg_walk #(
  parameter int NSEG = 8,
  parameter int AW   = 64,
  parameter int LW   = 32,
  localparam int NW  = $clog2(NSEG + 1),
  localparam int SW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LW-1:0]            total_i,
  input  logic [LW-1:0]            rsv_i,
  input  logic [NW-1:0]            nseg_i,
  input  logic [NSEG-1:0][AW-1:0]  seg_addr_i,
  input  logic [NSEG-1:0][LW-1:0]  seg_len_i,
  output logic                     done_o,
  output logic                     ext_valid_o,
  output logic [NW-1:0]            ext_idx_o,
  output logic [AW-1:0]            ext_addr_o,
  output logic [LW-1:0]            ext_len_o
);
  logic                    act_q;
  logic [NW-1:0]           idx_q, nseg_q;
  logic [LW-1:0]           left_q, skip_q;
  logic [NSEG-1:0][AW-1:0] addr_q;
  logic [NSEG-1:0][LW-1:0] len_q;

  logic [SW-1:0] sel;
  logic [LW-1:0] cur_len, part_len, use_len;
  logic          end_walk, skip_all;

  assign sel      = idx_q[SW-1:0];
  assign end_walk = (idx_q >= nseg_q) || (left_q == '0);
  assign cur_len  = len_q[sel];
  assign skip_all = skip_q >= cur_len;
  assign part_len = cur_len - skip_q;
  assign use_len  = (part_len > left_q) ? left_q : part_len;

  assign done_o      = act_q && end_walk;
  assign ext_valid_o = act_q && !end_walk && !skip_all;
  assign ext_idx_o   = idx_q;
  assign ext_addr_o  = addr_q[sel] + AW'(skip_q);
  assign ext_len_o   = use_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      nseg_q <= '0;
      left_q <= '0;
      skip_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      nseg_q <= (nseg_i > NW'(NSEG)) ? NW'(NSEG) : nseg_i;
      left_q <= (rsv_i < total_i) ? (total_i - rsv_i) : '0;
      skip_q <= rsv_i;
      addr_q <= seg_addr_i;
      len_q  <= seg_len_i;
    end else if (act_q) begin
      if (end_walk) begin
        act_q <= 1'b0;
      end else if (skip_all) begin
        skip_q <= skip_q - cur_len;
        idx_q  <= idx_q + 1'b1;
      end else begin
        skip_q <= '0;
        left_q <= left_q - use_len;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ucg_irq_gate.sv
module ucg_irq_gate
  import ucg_pkg::*;
#(
  parameter int SKIP_CW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eval_i,
  input  logic [15:0]        avail_flags_i,
  input  logic               notify_empty_i,
  input  logic               queue_empty_i,
  output logic               irq_o,
  output logic [7:0]         irq_cause_o,
  output logic [SKIP_CW-1:0] skip_cnt_o
);
  logic fire;

  assign fire        = !avail_flags_i[NO_IRQ_BIT] || (notify_empty_i && queue_empty_i);
  assign irq_o       = eval_i && fire;
  assign irq_cause_o = irq_o ? CAUSE_QUEUE : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              skip_cnt_o <= '0;
    else if (eval_i && !fire) skip_cnt_o <= skip_cnt_o + 1'b1;
  end
endmodule

// File: rtl/ucg_used_ring.sv
module ucg_used_ring
  import ucg_pkg::*;
#(
  parameter int NSEG      = 8,
  parameter int AW        = 64,
  parameter int RING_LOG2 = 4,
  parameter int SKIP_CW   = 16,
  localparam int NW       = $clog2(NSEG + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           used_base_i,
  input  logic                    cmp_valid_i,
  output logic                    ready_o,
  input  logic [31:0]             cmp_id_i,
  input  logic [31:0]             cmp_total_i,
  input  logic [31:0]             cmp_rsv_i,
  input  logic [NW-1:0]           cmp_nseg_i,
  input  logic [NSEG-1:0][AW-1:0] seg_addr_i,
  input  logic [NSEG-1:0][31:0]   seg_len_i,
  input  logic                    sync_i,
  input  logic [15:0]             avail_flags_i,
  input  logic                    notify_empty_i,
  input  logic                    queue_empty_i,
  input  logic                    flag_req_i,
  input  logic                    flag_enable_i,
  input  logic [15:0]             used_flags_i,
  output logic                    wr_valid_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [63:0]             wr_data_o,
  output logic [3:0]              wr_bytes_o,
  output logic                    ext_valid_o,
  output logic [NW-1:0]           ext_idx_o,
  output logic [AW-1:0]           ext_addr_o,
  output logic [31:0]             ext_len_o,
  output logic                    irq_o,
  output logic [7:0]              irq_cause_o,
  output logic [SKIP_CW-1:0]      skip_cnt_o
);
  ucg_state_e st_q, st_d;
  logic [15:0] used_idx_q;
  logic [31:0] id_q, total_q;
  logic        sync_pend_q, flag_pend_q, flag_en_q;
  logic [15:0] flag_word_q;
  logic        take_cmp, take_sync, take_flag, walk_done;
  logic [AW-1:0] elem_addr;

  assign take_cmp  = (st_q == ST_IDLE) && cmp_valid_i;
  assign take_sync = (st_q == ST_IDLE) && !cmp_valid_i && sync_pend_q;
  assign take_flag = (st_q == ST_IDLE) && !cmp_valid_i && !sync_pend_q && flag_pend_q;
  assign ready_o   = (st_q == ST_IDLE);

  ucg_seg_walk #(.NSEG(NSEG), .AW(AW), .LW(32)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (take_cmp),
    .total_i     (cmp_total_i),
    .rsv_i       (cmp_rsv_i),
    .nseg_i      (cmp_nseg_i),
    .seg_addr_i  (seg_addr_i),
    .seg_len_i   (seg_len_i),
    .done_o      (walk_done),
    .ext_valid_o (ext_valid_o),
    .ext_idx_o   (ext_idx_o),
    .ext_addr_o  (ext_addr_o),
    .ext_len_o   (ext_len_o)
  );

  ucg_irq_gate #(.SKIP_CW(SKIP_CW)) u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .eval_i         (st_q == ST_SYNC),
    .avail_flags_i  (avail_flags_i),
    .notify_empty_i (notify_empty_i),
    .queue_empty_i  (queue_empty_i),
    .irq_o          (irq_o),
    .irq_cause_o    (irq_cause_o),
    .skip_cnt_o     (skip_cnt_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (take_cmp)       st_d = ST_WALK;
        else if (take_sync) st_d = ST_SYNC;
        else if (take_flag) st_d = ST_FLAG;
      end
      ST_WALK: if (walk_done) st_d = ST_ELEM;
      ST_ELEM: st_d = ST_IDLE;
      ST_SYNC: st_d = ST_IDLE;
      ST_FLAG: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      used_idx_q  <= '0;
      id_q        <= '0;
      total_q     <= '0;
      sync_pend_q <= 1'b0;
      flag_pend_q <= 1'b0;
      flag_en_q   <= 1'b0;
      flag_word_q <= '0;
    end else begin
      st_q        <= st_d;
      sync_pend_q <= sync_i | (sync_pend_q & ~take_sync);
      flag_pend_q <= flag_req_i | (flag_pend_q & ~take_flag);
      if (flag_req_i) begin
        flag_en_q   <= flag_enable_i;
        flag_word_q <= used_flags_i;
      end
      if (take_cmp) begin
        id_q    <= cmp_id_i;
        total_q <= cmp_total_i;
      end
      if (st_q == ST_ELEM) used_idx_q <= used_idx_q + 16'd1;
    end
  end

  assign elem_addr = used_base_i + AW'(RING_OFF)
                   + (AW'(used_idx_q[RING_LOG2-1:0]) << ELEM_SHIFT);

  always_comb begin
    wr_valid_o = 1'b0;
    wr_addr_o  = '0;
    wr_data_o  = '0;
    wr_bytes_o = '0;
    unique case (st_q)
      ST_ELEM: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = elem_addr;
        wr_data_o  = {total_q, id_q};
        wr_bytes_o = 4'd8;
      end
      ST_SYNC: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = used_base_i + AW'(IDX_OFF);
        wr_data_o  = {48'd0, used_idx_q};
        wr_bytes_o = 4'd2;
      end
      ST_FLAG: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = used_base_i + AW'(FLAGS_OFF);
        wr_data_o  = {48'd0, flag_word_q[15:1], ~flag_en_q};
        wr_bytes_o = 4'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ucg_used_ring_chk.sv
module ucg_used_ring_chk #(
  parameter int AW      = 64,
  parameter int NW      = 4,
  parameter int SKIP_CW = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      used_base_i,
  input logic [15:0]        avail_flags_i,
  input logic               ready_o,
  input logic               wr_valid_o,
  input logic [AW-1:0]      wr_addr_o,
  input logic [3:0]         wr_bytes_o,
  input logic               ext_valid_o,
  input logic [NW-1:0]      ext_idx_o,
  input logic [31:0]        ext_len_o,
  input logic               irq_o,
  input logic [7:0]         irq_cause_o,
  input logic [SKIP_CW-1:0] skip_cnt_o
);
  logic idx_wr, elem_wr;
  assign idx_wr  = wr_valid_o && (wr_bytes_o == 4'd2) && (wr_addr_o == used_base_i + AW'(2));
  assign elem_wr = wr_valid_o && (wr_bytes_o == 4'd8);

  AST_ONE_PORT_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && ext_valid_o)); // R13
  AST_EXT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> (ext_len_o != 32'd0)); // R6
  AST_EXT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |=> (!ext_valid_o || (ext_idx_o > $past(ext_idx_o)))); // R5
  AST_EXT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> !ready_o); // R11
  AST_ELEM_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_wr |=> ready_o); // R2
  AST_IRQ_ON_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> idx_wr); // R9
  AST_IRQ_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && !avail_flags_i[0]) |-> irq_o); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_cause_o == 8'h01)); // R9
  AST_NO_CAUSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_cause_o == 8'h00)); // R9
  AST_SKIP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && !irq_o) |=> (skip_cnt_o == $past(skip_cnt_o) + 1'b1)); // R10
  AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idx_wr && !irq_o) |=> $stable(skip_cnt_o)); // R10
endmodule

bind ucg_used_ring ucg_used_ring_chk #(.AW(AW), .NW(NW), .SKIP_CW(SKIP_CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .used_base_i   (used_base_i),
  .avail_flags_i (avail_flags_i),
  .ready_o       (ready_o),
  .wr_valid_o    (wr_valid_o),
  .wr_addr_o     (wr_addr_o),
  .wr_bytes_o    (wr_bytes_o),
  .ext_valid_o   (ext_valid_o),
  .ext_idx_o     (ext_idx_o),
  .ext_len_o     (ext_len_o),
  .irq_o         (irq_o),
  .irq_cause_o   (irq_cause_o),
  .skip_cnt_o    (skip_cnt_o)
);

// File: tb/ucg_used_ring_tb.sv
`timescale 1ns/1ps
module ucg_used_ring_tb_top;
  localparam int NSEG = 8;
  localparam int AW = 64;
  localparam int RL2 = 4;
  localparam int SCW = 16;
  localparam int NW = $clog2(NSEG + 1);
  localparam logic [63:0] BASE = 64'h0000_0001_0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmp_valid = 0, sync = 0, flag_req = 0, flag_en = 0, noe = 0, qempty = 0;
  logic [31:0] cmp_id = 0, cmp_total = 0, cmp_rsv = 0;
  logic [NW-1:0] cmp_nseg = 0;
  logic [NSEG-1:0][AW-1:0] seg_addr = '0;
  logic [NSEG-1:0][31:0] seg_len = '0;
  logic [15:0] avail_flags = 0, used_flags = 0;
  logic ready, wr_valid, ext_valid, irq;
  logic [AW-1:0] wr_addr, ext_addr;
  logic [63:0] wr_data;
  logic [3:0] wr_bytes;
  logic [NW-1:0] ext_idx;
  logic [31:0] ext_len;
  logic [7:0] irq_cause;
  logic [SCW-1:0] skip_cnt;

  ucg_used_ring #(.NSEG(NSEG), .AW(AW), .RING_LOG2(RL2), .SKIP_CW(SCW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .used_base_i(BASE), .cmp_valid_i(cmp_valid), .ready_o(ready),
    .cmp_id_i(cmp_id), .cmp_total_i(cmp_total), .cmp_rsv_i(cmp_rsv), .cmp_nseg_i(cmp_nseg),
    .seg_addr_i(seg_addr), .seg_len_i(seg_len), .sync_i(sync), .avail_flags_i(avail_flags),
    .notify_empty_i(noe), .queue_empty_i(qempty), .flag_req_i(flag_req), .flag_enable_i(flag_en),
    .used_flags_i(used_flags), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_bytes_o(wr_bytes), .ext_valid_o(ext_valid), .ext_idx_o(ext_idx), .ext_addr_o(ext_addr),
    .ext_len_o(ext_len), .irq_o(irq), .irq_cause_o(irq_cause), .skip_cnt_o(skip_cnt));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int model_used = 0, model_skip = 0;

  // recorded traffic
  int n_ext, n_wr, n_irq;
  logic [63:0] g_eaddr [32];
  int g_eidx [32], g_elen [32];
  logic [63:0] g_waddr [16], g_wdata [16];
  int g_wbytes [16];
  bit g_wirq [16];
  // expected extents
  int n_x;
  logic [63:0] x_addr [NSEG];
  int x_idx [NSEG], x_len [NSEG];

  always @(negedge clk) if (rst_n) begin
    if (ext_valid) begin
      if (n_ext < 32) begin
        g_eaddr[n_ext] = ext_addr; g_eidx[n_ext] = int'(ext_idx); g_elen[n_ext] = int'(ext_len);
      end
      n_ext++;
    end
    if (wr_valid) begin
      if (n_wr < 16) begin
        g_waddr[n_wr] = wr_addr; g_wdata[n_wr] = wr_data;
        g_wbytes[n_wr] = int'(wr_bytes); g_wirq[n_wr] = irq;
      end
      n_wr++;
    end
    if (irq) begin
      n_irq++;
      if (irq_cause != 8'h01) begin n_chk++; n_fail++; $display("FAIL R9 cause: actual %0h expected 1", irq_cause); end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rec();
    n_ext = 0; n_wr = 0; n_irq = 0;
  endtask

  task automatic model_walk();
    longint skip, left, l;
    skip = cmp_rsv;
    left = (cmp_rsv < cmp_total) ? (cmp_total - cmp_rsv) : 0;
    n_x = 0;
    for (int i = 0; i < int'(cmp_nseg) && i < NSEG && left > 0; i++) begin
      if (skip >= seg_len[i]) begin
        skip -= seg_len[i];
      end else begin
        l = seg_len[i] - skip;
        if (l > left) l = left;
        x_idx[n_x] = i; x_addr[n_x] = seg_addr[i] + 64'(skip); x_len[n_x] = int'(l);
        n_x++; skip = 0; left -= l;
      end
    end
  endtask

  function automatic logic [63:0] elem_addr(input int u);
    return BASE + 64'd4 + 64'(8 * (u % (1 << RL2)));
  endfunction

  task automatic check_exts(input string req);
    chk(n_ext == n_x, req, "extent count", 64'(n_ext), 64'(n_x));
    for (int k = 0; k < n_x && k < n_ext; k++) begin
      chk(g_eidx[k] == x_idx[k], req, "extent index", 64'(g_eidx[k]), 64'(x_idx[k]));
      chk(g_eaddr[k] == x_addr[k], req, "extent addr", g_eaddr[k], x_addr[k]);
      chk(g_elen[k] == x_len[k], req, "extent len", 64'(g_elen[k]), 64'(x_len[k]));
    end
  endtask

  task automatic check_elem(input int w, input string req);
    chk(g_waddr[w] == elem_addr(model_used), req, "elem addr", g_waddr[w], elem_addr(model_used));
    chk(g_wdata[w] == {cmp_total, cmp_id}, req, "elem data", g_wdata[w], {cmp_total, cmp_id});
    chk(g_wbytes[w] == 8, req, "elem bytes", 64'(g_wbytes[w]), 64'd8);
    model_used++;
  endtask

  task automatic do_cmp(input string req);
    model_walk();
    clear_rec();
    @(posedge clk); #1 cmp_valid = 1;
    @(posedge clk); #1 cmp_valid = 0;
    repeat (NSEG + 6) @(posedge clk);
    check_exts(req);
    chk(n_wr == 1, req, "write count", 64'(n_wr), 64'd1);
    check_elem(0, req);
    chk(ready == 1'b1, req, "ready after", 64'(ready), 64'd1);
  endtask

  task automatic check_sync(input int w, input bit exp_irq, input string req);
    chk(g_waddr[w] == BASE + 64'd2, "R8", "index addr", g_waddr[w], BASE + 64'd2);
    chk(g_wdata[w] == 64'(model_used % 65536), "R8", "index value", g_wdata[w], 64'(model_used % 65536));
    chk(g_wbytes[w] == 2, "R8", "index bytes", 64'(g_wbytes[w]), 64'd2);
    chk(g_wirq[w] == exp_irq, req, "irq with index", 64'(g_wirq[w]), 64'(exp_irq));
    if (!exp_irq) model_skip++;
    chk(int'(skip_cnt) == model_skip, "R10", "skip count", 64'(skip_cnt), 64'(model_skip));
  endtask

  task automatic do_sync(input logic [15:0] af, input bit ne, input bit qe, input bit exp_irq, input string req);
    avail_flags = af; noe = ne; qempty = qe;
    clear_rec();
    @(posedge clk); #1 sync = 1;
    @(posedge clk); #1 sync = 0;
    repeat (4) @(posedge clk);
    chk(n_wr == 1, req, "sync write count", 64'(n_wr), 64'd1);
    chk(n_irq == int'(exp_irq), req, "irq count", 64'(n_irq), 64'(exp_irq));
    check_sync(0, exp_irq, req);
  endtask

  task automatic set_segs(input int n);
    cmp_nseg = NW'(n);
    for (int i = 0; i < NSEG; i++) seg_addr[i] = 64'h2000_0000 + 64'(i) * 64'h1000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sum;
    void'($urandom(32'd1357));
    clear_rec();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready", 64'(ready), 64'd1);
    chk(wr_valid == 1'b0 && ext_valid == 1'b0, "R1", "idle outputs", 64'({wr_valid, ext_valid}), 64'd0);
    chk(irq == 1'b0, "R1", "irq", 64'(irq), 64'd0);
    chk(skip_cnt == '0, "R1", "skip count", 64'(skip_cnt), 64'd0);

    // R1 R2 R5 R6: plain completion, last segment trimmed, slot 0
    set_segs(3); seg_len[0] = 10; seg_len[1] = 20; seg_len[2] = 30;
    cmp_id = 32'h0000_0007; cmp_total = 45; cmp_rsv = 0;
    do_cmp("R2");
    // R4 R5: reserved prefix spans segment 0 and part of segment 1
    cmp_id = 32'h0000_0003; cmp_total = 40; cmp_rsv = 15;
    do_cmp("R4");
    // R4: zero-length segment in the middle
    set_segs(4); seg_len[0] = 8; seg_len[1] = 0; seg_len[2] = 0; seg_len[3] = 16;
    cmp_id = 32'h11; cmp_total = 20; cmp_rsv = 8;
    do_cmp("R4");
    // R7: reserved equals total, then above total
    cmp_id = 32'h22; cmp_total = 12; cmp_rsv = 12;
    do_cmp("R7");
    cmp_id = 32'h23; cmp_total = 5; cmp_rsv = 9;
    do_cmp("R7");
    // R6: segments run out before the total
    set_segs(2); seg_len[0] = 30; seg_len[1] = 30;
    cmp_id = 32'h33; cmp_total = 100; cmp_rsv = 4;
    do_cmp("R6");

    // R8 R9 R10: interrupt decision
    do_sync(16'h0000, 0, 0, 1, "R9");
    do_sync(16'h0001, 1, 1, 1, "R9");
    do_sync(16'h0001, 1, 0, 0, "R10");
    do_sync(16'h0001, 0, 1, 0, "R10");

    // R3: random completions, crosses ring wrap
    for (int n = 0; n < 24; n++) begin
      sum = 0;
      set_segs($urandom_range(0, NSEG));
      for (int i = 0; i < NSEG; i++) begin
        seg_len[i] = $urandom_range(0, 40);
        if (i < int'(cmp_nseg)) sum += int'(seg_len[i]);
      end
      cmp_id = $urandom;
      cmp_total = $urandom_range(0, sum + 8);
      cmp_rsv = $urandom_range(0, cmp_total + 2);
      do_cmp("R3");
      if (n % 8 == 7) do_sync(16'h0000, 0, 0, 1, "R8");
    end

    // R13 R11: sync raised in the same cycle as a completion
    set_segs(2); seg_len[0] = 6; seg_len[1] = 6;
    cmp_id = 32'h44; cmp_total = 10; cmp_rsv = 2;
    avail_flags = 16'h0001; noe = 1; qempty = 1;
    model_walk(); clear_rec();
    @(posedge clk); #1 cmp_valid = 1; sync = 1;
    @(posedge clk); #1 cmp_valid = 0; sync = 0;
    repeat (NSEG + 8) @(posedge clk);
    check_exts("R13");
    chk(n_wr == 2, "R13", "write count", 64'(n_wr), 64'd2);
    chk(g_wbytes[0] == 8, "R13", "first write is element", 64'(g_wbytes[0]), 64'd8);
    check_elem(0, "R13");
    check_sync(1, 1, "R11");

    // R11: sync raised while the walk is running
    cmp_id = 32'h55; cmp_total = 12; cmp_rsv = 0;
    avail_flags = 16'h0001; noe = 0; qempty = 0;
    model_walk(); clear_rec();
    @(posedge clk); #1 cmp_valid = 1;
    @(posedge clk); #1 cmp_valid = 0; sync = 1;
    chk(ready == 1'b0, "R11", "busy during walk", 64'(ready), 64'd0);
    @(posedge clk); #1 sync = 0;
    repeat (NSEG + 8) @(posedge clk);
    check_exts("R11");
    chk(n_wr == 2, "R11", "write count", 64'(n_wr), 64'd2);
    check_elem(0, "R11");
    check_sync(1, 0, "R11");

    // R12: flag read-modify-write both ways
    clear_rec();
    @(posedge clk); #1 flag_req = 1; flag_en = 1; used_flags = 16'hA5A5;
    @(posedge clk); #1 flag_req = 0; used_flags = 16'h0;
    repeat (4) @(posedge clk);
    chk(n_wr == 1, "R12", "write count", 64'(n_wr), 64'd1);
    chk(g_waddr[0] == BASE, "R12", "flags addr", g_waddr[0], BASE);
    chk(g_wdata[0] == 64'hA5A4, "R12", "enable clears bit0", g_wdata[0], 64'hA5A4);
    chk(g_wbytes[0] == 2, "R12", "flags bytes", 64'(g_wbytes[0]), 64'd2);

    // R13 R12: flag update and sync in one cycle, sync first
    avail_flags = 16'h0000;
    clear_rec();
    @(posedge clk); #1 flag_req = 1; flag_en = 0; used_flags = 16'h1230; sync = 1;
    @(posedge clk); #1 flag_req = 0; sync = 0;
    repeat (6) @(posedge clk);
    chk(n_wr == 2, "R13", "write count", 64'(n_wr), 64'd2);
    check_sync(0, 1, "R13");
    chk(g_waddr[1] == BASE, "R13", "flags after index", g_waddr[1], BASE);
    chk(g_wdata[1] == 64'h1231, "R12", "disable sets bit0", g_wdata[1], 64'h1231);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule